// File: doc/BRIEF.md
# AHB-Lite to Dual APB Bridge

This block connects one AHB-Lite slave port to two APB buses. Both buses run in the AHB clock domain. Each bus advances on its own clock enable, which a per-bus divider makes from the AHB clock. One address bit picks the target bus. The bridge then runs the APB select and enable phases on that bus, waits for the peripheral to be ready, and returns the read data or an error to the AHB side.

Every APB access is 32 bits wide and word-aligned. For a byte or halfword write, the bridge takes the active lane of the AHB write data and copies it across all four byte lanes. The peripheral therefore sees the same value wherever it decodes the narrow field. The bridge handles one transfer at a time: it stalls the AHB data phase until the APB transfer ends, and it accepts a new address phase only while it is idle.

The address, write flag and write data lines are shared by both buses. Select, enable, ready, error and read data are separate for each bus.

Top module: `ahb2apb_dual_bridge`

## Requirements
- R1: After reset, hready_out is 1, hresp is 0, and both bits of apb_sel and apb_enable are 0.
- R2: An accepted transfer with haddr bit 16 equal to 0 runs on bus 0 (apb_sel[0]). With that bit equal to 1 it runs on bus 1 (apb_sel[1]). At most one select is high at any time.
- R3: div_selN sets bus N's enable period to r = 2^div_selN cycles. Any value of 4 or more gives r = 16. With the peripheral ready at once, the setup phase lasts exactly r cycles and the access phase exactly r cycles.
- R4: Each bus keeps its own ratio; changing one bus's divider setting leaves the other bus's phase lengths unchanged.
- R5: apb_enable rises only after at least one cycle with apb_sel high and apb_enable low. apb_enable is never high without apb_sel. apb_addr is stable while apb_sel is held.
- R6: The access phase ends only on an enabled cycle where apb_ready is high. If ready rises k·r cycles into the access phase, that phase lasts (k+1)·r cycles.
- R7: hready_out is low from the cycle after the address phase is accepted until the APB transfer completes, and throughout any cycle where a select is high.
- R8: A read returns the selected bus's apb_rdata on hrdata with hresp 0, in the cycle where hready_out returns high.
- R9: A byte write (hsize 0) drives apb_wdata with the byte from lane haddr[1:0] repeated four times. apb_addr is haddr with bits [1:0] cleared.
- R10: A halfword write (hsize 1) drives apb_wdata with the halfword selected by haddr[1] repeated twice.
- R11: A word write (hsize 2) passes hwdata unchanged, with apb_write high.
- R12: A completed transfer with apb_slverr high gives a two-cycle error: first hresp 1 with hready_out 0, then hresp 1 with hready_out 1. The next transfer then ends with hresp 0.
- R13: Only htrans 2'b10 or 2'b11 with hsel and hready_in high starts a transfer. When htrans is 2'b00, or hsel is low, no select rises and hready_out stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for AHB and both APB buses |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select from the AHB decoder |
| haddr | input | AW | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB write flag |
| hsize | input | 3 | AHB transfer size |
| hwdata | input | 32 | AHB write data (data phase) |
| hready_in | input | 1 | Bus-wide ready seen by the slave |
| hready_out | output | 1 | Slave ready, registered |
| hresp | output | 1 | Slave error response, registered |
| hrdata | output | 32 | Read data, registered |
| div_sel0 | input | 3 | Clock-enable divider setting for bus 0 |
| div_sel1 | input | 3 | Clock-enable divider setting for bus 1 |
| apb_addr | output | AW | Word-aligned APB address, shared |
| apb_write | output | 1 | APB write flag, shared |
| apb_wdata | output | 32 | APB write data (lane-replicated), shared |
| apb_sel | output | 2 | Per-bus select |
| apb_enable | output | 2 | Per-bus enable |
| apb_rdata0 | input | 32 | Bus 0 read data |
| apb_rdata1 | input | 32 | Bus 1 read data |
| apb_ready | input | 2 | Per-bus ready |
| apb_slverr | input | 2 | Per-bus error |

## Verification
Reads are issued on each bus at several divider settings, including one above the clamp. This shows whether the select and enable phase lengths follow each bus's own ratio or leak from the other bus. A delayed ready in the access phase separates a bridge that samples ready only on enabled cycles from one that samples it on every clock. Byte, halfword and word writes to non-zero lanes expose a wrong lane choice or a missing replication. An error transfer followed by a clean read shows whether the error response has the right cycle shape and is cleared afterwards. Idle cycles with hsel high check that no transfer starts when htrans is idle.

// File: rtl/apbx_pkg.sv
package apbx_pkg;
  localparam int DW    = 32;
  localparam int NBUS  = 2;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_ACCESS,
    ST_ERR
  } brg_state_t;

  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;

  // Spread the active byte or halfword lane over the whole word.
  function automatic logic [DW-1:0] widen_wdata(input logic [2:0] size,
                                                input logic [1:0] lane,
                                                input logic [DW-1:0] d);
    logic [7:0]  b;
    logic [15:0] h;
    case (lane)
      2'd0:    b = d[7:0];
      2'd1:    b = d[15:8];
      2'd2:    b = d[23:16];
      default: b = d[31:24];
    endcase
    h = lane[1] ? d[31:16] : d[15:0];
    case (size)
      3'd0:    return {4{b}};
      3'd1:    return {2{h}};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/apbx_ce_gen.sv
module apbx_ce_gen #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             ce
);
  localparam int CNT_W = MAX_LOG;

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] shamt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim;

  always_comb begin
    shamt = (div_sel > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : div_sel;
    span  = (CNT_W+1)'(1) << shamt;
    lim   = span[CNT_W-1:0] - CNT_W'(1);
  end

  // Greater-or-equal lets a lowered ratio take effect without a long wrap.
  assign ce = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (ce) cnt <= '0;
    else         cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/apbx_decode.sv
module apbx_decode #(
  parameter int AW      = 32,
  parameter int SEL_BIT = 16
) (
  input  logic [AW-1:0] haddr,
  output logic          bus,
  output logic [AW-1:0] word_addr,
  output logic [1:0]    lane
);
  assign bus       = haddr[SEL_BIT];
  assign word_addr = {haddr[AW-1:2], 2'b00};
  assign lane      = haddr[1:0];
endmodule

// File: rtl/apbx_seq.sv
module apbx_seq
  import apbx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUS-1:0] ce_i,
  input  logic            take_i,
  input  logic            bus_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            write_i,
  input  logic [2:0]      size_i,
  input  logic [1:0]      lane_i,
  input  logic [DW-1:0]   hwdata_i,
  input  logic [NBUS-1:0] ready_i,
  input  logic [NBUS-1:0] slverr_i,
  input  logic [DW-1:0]   rdata0_i,
  input  logic [DW-1:0]   rdata1_i,
  output logic            hready_o,
  output logic            hresp_o,
  output logic [DW-1:0]   hrdata_o,
  output logic [NBUS-1:0] psel_o,
  output logic [NBUS-1:0] penable_o,
  output logic [AW-1:0]   paddr_o,
  output logic            pwrite_o,
  output logic [DW-1:0]   pwdata_o
);
  brg_state_t      st;
  logic            bus_q;
  logic [2:0]      size_q;
  logic [1:0]      lane_q;
  logic            ce_hit, rdy_hit, err_hit;
  logic [DW-1:0]   rd_hit;

  assign ce_hit  = ce_i[bus_q];
  assign rdy_hit = ready_i[bus_q];
  assign err_hit = slverr_i[bus_q];
  assign rd_hit  = bus_q ? rdata1_i : rdata0_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      hready_o  <= 1'b1;
      hresp_o   <= 1'b0;
      hrdata_o  <= '0;
      psel_o    <= '0;
      penable_o <= '0;
      paddr_o   <= '0;
      pwrite_o  <= 1'b0;
      pwdata_o  <= '0;
      bus_q     <= 1'b0;
      size_q    <= '0;
      lane_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          hresp_o  <= 1'b0;
          hready_o <= 1'b1;
          if (take_i) begin
            bus_q    <= bus_i;
            paddr_o  <= addr_i;
            pwrite_o <= write_i;
            size_q   <= size_i;
            lane_q   <= lane_i;
            hready_o <= 1'b0;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          // hwdata is held by the master while hready_o stays low.
          if (ce_hit) begin
            psel_o <= NBUS'(1) << bus_q;
            if (pwrite_o) pwdata_o <= widen_wdata(size_q, lane_q, hwdata_i);
            st <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (ce_hit) begin
            penable_o <= psel_o;
            st        <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (ce_hit && rdy_hit) begin
            psel_o    <= '0;
            penable_o <= '0;
            if (err_hit) begin
              hresp_o <= 1'b1;
              st      <= ST_ERR;
            end else begin
              hready_o <= 1'b1;
              if (!pwrite_o) hrdata_o <= rd_hit;
              st <= ST_IDLE;
            end
          end
        end
        ST_ERR: begin
          hready_o <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ahb2apb_dual_bridge.sv
module ahb2apb_dual_bridge
  import apbx_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SEL_BIT = 16,
  parameter int MAX_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsel,
  input  logic [AW-1:0]    haddr,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic [DW-1:0]    hwdata,
  input  logic             hready_in,
  output logic             hready_out,
  output logic             hresp,
  output logic [DW-1:0]    hrdata,
  input  logic [SEL_W-1:0] div_sel0,
  input  logic [SEL_W-1:0] div_sel1,
  output logic [AW-1:0]    apb_addr,
  output logic             apb_write,
  output logic [DW-1:0]    apb_wdata,
  output logic [NBUS-1:0]  apb_sel,
  output logic [NBUS-1:0]  apb_enable,
  input  logic [DW-1:0]    apb_rdata0,
  input  logic [DW-1:0]    apb_rdata1,
  input  logic [NBUS-1:0]  apb_ready,
  input  logic [NBUS-1:0]  apb_slverr
);
  logic [NBUS-1:0][SEL_W-1:0] div_all;
  logic [NBUS-1:0]            ce;
  logic                       take;
  logic                       dec_bus;
  logic [AW-1:0]              dec_addr;
  logic [1:0]                 dec_lane;

  assign div_all = {div_sel1, div_sel0};
  assign take    = hsel && hready_in && (htrans inside {HT_NONSEQ, HT_SEQ});

  for (genvar g = 0; g < NBUS; g++) begin : g_ce
    apbx_ce_gen #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_ce (
      .clk     (clk),
      .rst     (rst),
      .div_sel (div_all[g]),
      .ce      (ce[g])
    );
  end

  apbx_decode #(.AW(AW), .SEL_BIT(SEL_BIT)) u_dec (
    .haddr     (haddr),
    .bus       (dec_bus),
    .word_addr (dec_addr),
    .lane      (dec_lane)
  );

  apbx_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ce_i      (ce),
    .take_i    (take),
    .bus_i     (dec_bus),
    .addr_i    (dec_addr),
    .write_i   (hwrite),
    .size_i    (hsize),
    .lane_i    (dec_lane),
    .hwdata_i  (hwdata),
    .ready_i   (apb_ready),
    .slverr_i  (apb_slverr),
    .rdata0_i  (apb_rdata0),
    .rdata1_i  (apb_rdata1),
    .hready_o  (hready_out),
    .hresp_o   (hresp),
    .hrdata_o  (hrdata),
    .psel_o    (apb_sel),
    .penable_o (apb_enable),
    .paddr_o   (apb_addr),
    .pwrite_o  (apb_write),
    .pwdata_o  (apb_wdata)
  );
endmodule

// File: rtl/apbx_bridge_chk.sv
module apbx_bridge_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          hready_out,
  input logic          hresp,
  input logic [1:0]    apb_sel,
  input logic [1:0]    apb_enable,
  input logic [AW-1:0] apb_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> (hready_out && !hresp && apb_sel == 2'b00 && apb_enable == 2'b00));

  assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(apb_sel));

  assert_enable_needs_sel_R5: assert property (@(posedge clk) disable iff (rst)
    (apb_enable & ~apb_sel) == 2'b00);

  assert_setup_first_bus0_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(apb_enable[0]) |-> $past(apb_sel[0] && !apb_enable[0]));

  assert_setup_first_bus1_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(apb_enable[1]) |-> $past(apb_sel[1] && !apb_enable[1]));

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (|(apb_sel & $past(apb_sel))) |-> $stable(apb_addr));

  assert_hready_low_R7: assert property (@(posedge clk) disable iff (rst)
    (|apb_sel) |-> !hready_out);

  assert_err_two_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    (hresp && !hready_out) |=> (hresp && hready_out));
endmodule

bind ahb2apb_dual_bridge apbx_bridge_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hready_out (hready_out),
  .hresp      (hresp),
  .apb_sel    (apb_sel),
  .apb_enable (apb_enable),
  .apb_addr   (apb_addr)
);

// File: tb/ahb2apb_dual_bridge_tb.sv
module ahb2apb_dual_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic [31:0] hwdata = '0;
  logic        hready_out, hresp;
  logic [31:0] hrdata;
  logic [2:0]  div_sel0 = 3'd0, div_sel1 = 3'd0;
  logic [31:0] apb_addr, apb_wdata, apb_rdata0, apb_rdata1;
  logic        apb_write;
  logic [1:0]  apb_sel, apb_enable, apb_ready, apb_slverr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Peripheral model: ready after wait_cfg cycles of enable, optional error.
  int acc_cnt0 = 0, acc_cnt1 = 0;
  int wait_cfg0 = 0, wait_cfg1 = 0;
  bit err_cfg0 = 0, err_cfg1 = 0;

  always #4 clk = ~clk;

  ahb2apb_dual_bridge u_dut (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready_in(hready_out),
    .hready_out(hready_out), .hresp(hresp), .hrdata(hrdata),
    .div_sel0(div_sel0), .div_sel1(div_sel1),
    .apb_addr(apb_addr), .apb_write(apb_write), .apb_wdata(apb_wdata),
    .apb_sel(apb_sel), .apb_enable(apb_enable),
    .apb_rdata0(apb_rdata0), .apb_rdata1(apb_rdata1),
    .apb_ready(apb_ready), .apb_slverr(apb_slverr)
  );

  always @(posedge clk) begin
    acc_cnt0 <= apb_enable[0] ? acc_cnt0 + 1 : 0;
    acc_cnt1 <= apb_enable[1] ? acc_cnt1 + 1 : 0;
  end
  assign apb_ready[0]  = (acc_cnt0 >= wait_cfg0);
  assign apb_ready[1]  = (acc_cnt1 >= wait_cfg1);
  assign apb_slverr[0] = err_cfg0 & apb_enable[0];
  assign apb_slverr[1] = err_cfg1 & apb_enable[1];
  assign apb_rdata0    = ~apb_addr;
  assign apb_rdata1    = apb_addr ^ 32'h5A5A_0000;

  // Phase monitor, sampled at the falling edge.
  int sel_cnt[2], en_cnt[2], sel_len[2], en_len[2], done_cnt[2];
  logic [31:0] mon_addr[2], mon_wdata[2];
  logic mon_wr[2];
  logic prev_sel[2];
  initial for (int i = 0; i < 2; i++) begin
    sel_cnt[i] = 0; en_cnt[i] = 0; sel_len[i] = 0; en_len[i] = 0;
    done_cnt[i] = 0; prev_sel[i] = 0; mon_addr[i] = '0; mon_wdata[i] = '0; mon_wr[i] = 0;
  end
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (apb_sel[i]) begin
        sel_cnt[i]++;
        if (apb_enable[i]) en_cnt[i]++;
        mon_addr[i]  = apb_addr;
        mon_wdata[i] = apb_wdata;
        mon_wr[i]    = apb_write;
      end else if (prev_sel[i]) begin
        sel_len[i] = sel_cnt[i];
        en_len[i]  = en_cnt[i];
        sel_cnt[i] = 0;
        en_cnt[i]  = 0;
        done_cnt[i]++;
      end
      prev_sel[i] = apb_sel[i];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output bit resp, output bit err_first, output int low);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = wr; hsize = sz;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    low = 0; err_first = 0;
    while (hready_out !== 1'b1) begin
      low++;
      if (hresp === 1'b1) err_first = 1;
      @(negedge clk);
    end
    rd = hrdata;
    resp = hresp;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(hready_out === 1'b1 && hresp === 1'b0, "R1 ahb idle", {hready_out, hresp}, 2'b10);
    chk(apb_sel === 2'b00 && apb_enable === 2'b00, "R1 apb idle", {apb_sel, apb_enable}, 0);
  endtask

  task automatic t_ratio(input int bus, input logic [2:0] sel, input int r);
    logic [31:0] rd, a, exp; bit resp, ef; int low, d0, d1;
    if (bus == 0) div_sel0 = sel; else div_sel1 = sel;
    wait_cfg0 = 0; wait_cfg1 = 0;
    repeat (20) @(negedge clk);
    a = (bus == 0) ? 32'h0000_1230 : 32'h0001_0450;
    d0 = done_cnt[0]; d1 = done_cnt[1];
    xfer(0, a, 3'd2, 0, rd, resp, ef, low);
    exp = (bus == 0) ? ~a : (a ^ 32'h5A5A_0000);
    chk(sel_len[bus] == 2 * r, "R3 select length", sel_len[bus], 2 * r);
    chk(en_len[bus] == r, "R3 enable length", en_len[bus], r);
    chk(rd === exp && resp === 1'b0, "R8 read data", rd, exp);
    chk((done_cnt[bus] - ((bus == 0) ? d0 : d1)) == 1 &&
        (done_cnt[1-bus] - ((bus == 0) ? d1 : d0)) == 0,
        "R2 decode target", done_cnt[bus], bus);
  endtask

  task automatic t_independent;
    logic [31:0] rd; bit resp, ef; int low;
    div_sel0 = 3'd1; div_sel1 = 3'd3;
    repeat (20) @(negedge clk);
    xfer(0, 32'h0000_0040, 3'd2, 0, rd, resp, ef, low);
    chk(en_len[0] == 2, "R4 bus0 ratio 2 with bus1 at 8", en_len[0], 2);
    xfer(0, 32'h0001_0040, 3'd2, 0, rd, resp, ef, low);
    chk(en_len[1] == 8, "R4 bus1 ratio 8", en_len[1], 8);
    div_sel1 = 3'd0;
    repeat (20) @(negedge clk);
    xfer(0, 32'h0000_0044, 3'd2, 0, rd, resp, ef, low);
    chk(en_len[0] == 2, "R4 bus0 unchanged after bus1 change", en_len[0], 2);
  endtask

  task automatic t_wait;
    logic [31:0] rd; bit resp, ef; int low;
    div_sel0 = 3'd1; wait_cfg0 = 4;
    repeat (20) @(negedge clk);
    xfer(0, 32'h0000_0080, 3'd2, 0, rd, resp, ef, low);
    chk(en_len[0] == 6, "R6 access stretched by wait", en_len[0], 6);
    chk(sel_len[0] == 8, "R6 select length with wait", sel_len[0], 8);
    chk(low >= sel_len[0], "R7 hready low over transfer", low, sel_len[0]);
    wait_cfg0 = 0;
  endtask

  task automatic t_writes;
    logic [31:0] rd; bit resp, ef; int low;
    div_sel0 = 3'd0; div_sel1 = 3'd2;
    repeat (20) @(negedge clk);
    xfer(1, 32'h0000_0102, 3'd0, 32'h1122_3344, rd, resp, ef, low);
    chk(mon_wdata[0] === 32'h2222_2222, "R9 byte replicated", mon_wdata[0], 32'h2222_2222);
    chk(mon_addr[0] === 32'h0000_0100, "R9 word aligned address", mon_addr[0], 32'h0000_0100);
    xfer(1, 32'h0001_0207, 3'd0, 32'hA1B2_C3D4, rd, resp, ef, low);
    chk(mon_wdata[1] === 32'hA1A1_A1A1, "R9 byte lane 3 on bus1", mon_wdata[1], 32'hA1A1_A1A1);
    xfer(1, 32'h0000_0302, 3'd1, 32'h1122_3344, rd, resp, ef, low);
    chk(mon_wdata[0] === 32'h1122_1122, "R10 upper halfword", mon_wdata[0], 32'h1122_1122);
    xfer(1, 32'h0000_0300, 3'd1, 32'h1122_3344, rd, resp, ef, low);
    chk(mon_wdata[0] === 32'h3344_3344, "R10 lower halfword", mon_wdata[0], 32'h3344_3344);
    xfer(1, 32'h0001_0400, 3'd2, 32'hDEAD_BEEF, rd, resp, ef, low);
    chk(mon_wdata[1] === 32'hDEAD_BEEF && mon_wr[1] === 1'b1, "R11 word write",
        mon_wdata[1], 32'hDEAD_BEEF);
  endtask

  task automatic t_error;
    logic [31:0] rd; bit resp, ef; int low;
    div_sel1 = 3'd0; err_cfg1 = 1;
    repeat (5) @(negedge clk);
    xfer(0, 32'h0001_0010, 3'd2, 0, rd, resp, ef, low);
    chk(ef == 1'b1, "R12 first error cycle", ef, 1);
    chk(resp == 1'b1, "R12 second error cycle", resp, 1);
    err_cfg1 = 0;
    xfer(0, 32'h0001_0014, 3'd2, 0, rd, resp, ef, low);
    chk(resp == 1'b0 && ef == 1'b0, "R12 error cleared", resp, 0);
  endtask

  task automatic t_idle;
    int d0, d1; bit bad;
    d0 = done_cnt[0]; d1 = done_cnt[1]; bad = 0;
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b00; haddr = 32'h0000_0500;
    repeat (6) begin
      @(negedge clk);
      if (hready_out !== 1'b1 || apb_sel !== 2'b00) bad = 1;
    end
    hsel = 1'b0; htrans = 2'b10; haddr = 32'h0001_0500;
    repeat (6) begin
      @(negedge clk);
      if (hready_out !== 1'b1 || apb_sel !== 2'b00) bad = 1;
    end
    htrans = 2'b00;
    repeat (20) @(negedge clk);
    chk(!bad && done_cnt[0] == d0 && done_cnt[1] == d1, "R13 no transfer started",
        bad, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ratio(0, 3'd0, 1);
    t_ratio(0, 3'd1, 2);
    t_ratio(1, 3'd2, 4);
    t_ratio(1, 3'd4, 16);
    t_ratio(1, 3'd6, 16);
    t_independent();
    t_wait();
    t_writes();
    t_error();
    t_idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule